// File: doc/BRIEF.md
# Set/Clear Register Interrupt Controller

This block is a memory-mapped interrupt controller. Its configuration lives in seven 32-bit state registers. Software never has to read, modify and write them back: each register has one address that ORs the write data into it and a second address that clears every bit written as 1. A simple register bus (byte address, write enable, write data, combinational read data) reaches a 256-byte window.

Each interrupt input is registered once. It is then qualified by a per-source trigger type: off, rising edge, falling edge, either edge, high level or low level. Edge sources latch a pending bit. Level sources follow the registered input. The active sources that are enabled are steered to one of two request outputs. Both requests are ORed into a single CPU interrupt line. Two of the clear addresses are also read ports that return the live status word behind each request, so a handler can find its sources with one read.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset every state register reads as zero and `req0_o`, `req1_o` and `cpu_irq_o` are low.
- R2: A write to a register's set address (config0 0x40, config1 0x48, config2 0x50, source 0x58, assign 0x60, wakeup 0x68, mask 0x70) ORs the write data into that register. The register is updated at the clock edge that accepts the write.
- R3: A write to a register's clear address (the set address plus 4) clears each register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: Reading either address of a register returns its current value. The exceptions are given in R5 and R6.
- R5: A read of 0x54 returns the request-0 status word: active AND mask AND NOT assign, one bit per source.
- R6: A read of 0x5C returns the request-1 status word: active AND mask AND assign.
- R7: Offsets outside 0x40..0x77, and offsets that are not word-aligned, read as zero. Writes to them change no register.
- R8: A source's trigger code is {config2[i], config1[i], config0[i]}. The codes are: 0 off, 1 rising edge, 2 falling edge, 3 either edge, 4 high level, 5 low level. Codes 6 and 7 behave as off.
- R9: An edge-mode source sets a pending bit on its configured edge. The bit stays set after the input returns to its idle level. Writing a 1 for that source to the mask clear address (0x74) clears both the pending bit and the mask bit.
- R10: A level-mode source is active exactly while its registered input is at the configured level.
- R11: An active source whose mask bit is 1 drives `req1_o` when its assign bit is 1 and drives `req0_o` when its assign bit is 0. Each request is the OR of its status word.
- R12: `cpu_irq_o` is high whenever `req0_o` or `req1_o` is high.
- R13: A source with mask bit 0 affects neither request. Its pending bit is still latched, and it raises its request as soon as the mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset within the window |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_in | input | 32 | Raw interrupt inputs, one per source |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| cpu_irq_o | output | 1 | Combined CPU interrupt |

## Verification
A wrong register bit shows up at once in the combinational read data for either of its addresses. It also shows up at a request pin, but only while the matching source is active. A stuck or lost pending bit is seen two clocks after the input edge, because the input is captured before the pending bit is set. The bench checks that the bit survives the input returning to idle and that it disappears on the cycle after the mask clear write. Routing errors appear as the wrong request pin rising, and they are cross-checked against the two aliased status reads.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int NUM_REGS = 7;
  localparam int REG_CFG0 = 0;
  localparam int REG_CFG1 = 1;
  localparam int REG_CFG2 = 2;
  localparam int REG_SRC  = 3;
  localparam int REG_ASGN = 4;
  localparam int REG_WAKE = 5;
  localparam int REG_MASK = 6;

  localparam logic [2:0] TRIG_OFF  = 3'd0;
  localparam logic [2:0] TRIG_RISE = 3'd1;
  localparam logic [2:0] TRIG_FALL = 3'd2;
  localparam logic [2:0] TRIG_BOTH = 3'd3;
  localparam logic [2:0] TRIG_HIGH = 3'd4;
  localparam logic [2:0] TRIG_LOW  = 3'd5;

  function automatic logic is_edge_mode(input logic [2:0] code);
    return (code == TRIG_RISE) || (code == TRIG_FALL) || (code == TRIG_BOTH);
  endfunction

  function automatic logic edge_hit(input logic [2:0] code, input logic cur, input logic prev);
    case (code)
      TRIG_RISE: return cur & ~prev;
      TRIG_FALL: return ~cur & prev;
      TRIG_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic level_hit(input logic [2:0] code, input logic cur);
    case (code)
      TRIG_HIGH: return cur;
      TRIG_LOW:  return ~cur;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ic_regbank.sv
module ic_regbank #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NREGS-1:0]             wr_set,
  input  logic [NREGS-1:0]             wr_clr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NREGS-1:0][DATA_W-1:0] regs_q
);
  function automatic logic [DATA_W-1:0] apply_write(
    input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] d,
    input logic s, input logic c);
    if (s) return old | d;
    if (c) return old & ~d;
    return old;
  endfunction

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[r] <= '0;
      else        regs_q[r] <= apply_write(regs_q[r], wdata, wr_set[r], wr_clr[r]);
    end
  end
endmodule

// File: rtl/ic_trigger.sv
module ic_trigger
  import ic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] cfg0,
  input  logic [NSRC-1:0] cfg1,
  input  logic [NSRC-1:0] cfg2,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] edge_evt,
  output logic [NSRC-1:0] active
);
  logic [NSRC-1:0] cap_q, prev_q, pend_q, pend_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      cap_q  <= irq_in;
      prev_q <= cap_q;
      pend_q <= pend_d;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [2:0] code;
    assign code        = {cfg2[i], cfg1[i], cfg0[i]};
    assign edge_evt[i] = edge_hit(code, cap_q[i], prev_q[i]);
    assign pend_d[i]   = is_edge_mode(code) ? ((pend_q[i] & ~ack[i]) | edge_evt[i]) : 1'b0;
    assign active[i]   = is_edge_mode(code) ? pend_q[i] : level_hit(code, cap_q[i]);
  end
endmodule

// File: rtl/ic_router.sv
module ic_router #(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32
) (
  input  logic [NSRC-1:0]   active,
  input  logic [NSRC-1:0]   mask,
  input  logic [NSRC-1:0]   asgn,
  output logic [DATA_W-1:0] stat0,
  output logic [DATA_W-1:0] stat1,
  output logic              req0,
  output logic              req1
);
  function automatic logic [NSRC-1:0] route(
    input logic [NSRC-1:0] a, input logic [NSRC-1:0] m,
    input logic [NSRC-1:0] g, input logic to_one);
    return a & m & (to_one ? g : ~g);
  endfunction

  logic [NSRC-1:0] s0, s1;
  assign s0    = route(active, mask, asgn, 1'b0);
  assign s1    = route(active, mask, asgn, 1'b1);
  assign stat0 = DATA_W'(s0);
  assign stat1 = DATA_W'(s1);
  assign req0  = |s0;
  assign req1  = |s1;
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import ic_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NSRC     = 32,
  parameter int BASE_OFF = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   irq_in,
  output logic              req0_o,
  output logic              req1_o,
  output logic              cpu_irq_o
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(BASE_OFF + NUM_REGS * 8);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [ADDR_W-1:0]              rel;
  logic [IDX_W-1:0]               idx;
  logic                           in_win, is_clr;
  logic [NUM_REGS-1:0]            wr_set, wr_clr;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0]              mask_q, stat0, stat1;
  logic [NSRC-1:0]                ack, active, edge_evt;

  assign rel    = bus_addr - WIN_LO;
  assign idx    = rel[3 +: IDX_W];
  assign is_clr = bus_addr[2];
  assign in_win = (bus_addr >= WIN_LO) && (bus_addr < WIN_HI) && (bus_addr[1:0] == 2'b00);

  always_comb begin
    wr_set = '0;
    wr_clr = '0;
    if (bus_we && in_win) begin
      if (is_clr) wr_clr[idx] = 1'b1;
      else        wr_set[idx] = 1'b1;
    end
  end

  assign mask_q = regs_q[REG_MASK];
  assign ack    = wr_clr[REG_MASK] ? bus_wdata[NSRC-1:0] : '0;

  ic_regbank #(.DATA_W(DATA_W), .NREGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
    .wdata(bus_wdata), .regs_q(regs_q));

  ic_trigger #(.NSRC(NSRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg0(regs_q[REG_CFG0][NSRC-1:0]), .cfg1(regs_q[REG_CFG1][NSRC-1:0]),
    .cfg2(regs_q[REG_CFG2][NSRC-1:0]), .ack(ack),
    .edge_evt(edge_evt), .active(active));

  ic_router #(.NSRC(NSRC), .DATA_W(DATA_W)) u_route (
    .active(active), .mask(mask_q[NSRC-1:0]), .asgn(regs_q[REG_ASGN][NSRC-1:0]),
    .stat0(stat0), .stat1(stat1), .req0(req0_o), .req1(req1_o));

  assign cpu_irq_o = req0_o | req1_o;

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      if (is_clr && (int'(idx) == REG_CFG2))     bus_rdata = stat0;
      else if (is_clr && (int'(idx) == REG_SRC)) bus_rdata = stat1;
      else                                       bus_rdata = regs_q[idx];
    end
  end
endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BASE_OFF = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              req0_o,
  input logic              req1_o,
  input logic [DATA_W-1:0] mask_q
);
  localparam logic [ADDR_W-1:0] A_MASK_SET = ADDR_W'(BASE_OFF + 'h30);
  localparam logic [ADDR_W-1:0] A_MASK_CLR = ADDR_W'(BASE_OFF + 'h34);
  localparam logic [ADDR_W-1:0] A_STAT0    = ADDR_W'(BASE_OFF + 'h14);
  localparam logic [ADDR_W-1:0] A_STAT1    = ADDR_W'(BASE_OFF + 'h1C);
  localparam logic [ADDR_W-1:0] A_LO       = ADDR_W'(BASE_OFF);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MASK_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MASK_CLR) |=> ((mask_q & $past(bus_wdata)) == '0));
  // R5
  stat0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT0) |-> ((bus_rdata != '0) == req0_o));
  // R6
  stat1_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT1) |-> ((bus_rdata != '0) == req1_o));
  // R7
  low_hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < A_LO) |-> (bus_rdata == '0));
  // R7
  low_hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr < A_LO) |=> $stable(mask_q));
  // R13
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!req0_o && !req1_o));
endmodule

bind irq_setclr_ctrl ic_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_OFF(BASE_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req0_o(req0_o),
  .req1_o(req1_o), .mask_q(mask_q));

// File: tb/tb_irq_setclr_ctrl.sv
`timescale 1ns/1ps
module tb_irq_setclr_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        req0_o, req1_o, cpu_irq_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_setclr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .req0_o(req0_o), .req1_o(req1_o), .cpu_irq_o(cpu_irq_o));

  // monitor: compares each queued expectation shortly after the negedge it was posted
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (kind_q.size() > 0) begin
        int k;
        logic [31:0] e, a;
        string t;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        case (k)
          0: a = bus_rdata;
          1: a = {31'b0, req0_o};
          2: a = {31'b0, req1_o};
          default: a = {31'b0, cpu_irq_o};
        endcase
        nchk++;
        if (a !== e) begin
          nfail++;
          $display("FAIL %s kind=%0d addr=%02h actual=%08h expected=%08h", t, k, bus_addr, a, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic pin(input int k, input logic e, input string t);
    @(negedge clk);
    kind_q.push_back(k); exp_q.push_back({31'b0, e}); tag_q.push_back(t);
  endtask

  task automatic drive(input int s, input logic v);
    @(negedge clk);
    irq_in[s] = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 'h40; a < 'h78; a += 4) rd(8'(a), 32'h0, "R1");
    pin(1, 0, "R1"); pin(2, 0, "R1"); pin(3, 0, "R1");
    // R2 set ORs in, R4 both addresses read the value
    wr(8'h40, 32'hF0); wr(8'h40, 32'h0F);
    rd(8'h40, 32'hFF, "R2"); rd(8'h44, 32'hFF, "R4");
    // R3 clear
    wr(8'h44, 32'h3C);
    rd(8'h40, 32'hC3, "R3");
    // R7 unlisted and unaligned offsets
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h7C, 32'hFFFF_FFFF); wr(8'h42, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R7"); rd(8'h7C, 32'h0, "R7"); rd(8'h42, 32'h0, "R7");
    rd(8'h40, 32'hC3, "R7"); rd(8'h70, 32'h0, "R7");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R3");
    // R4 plain storage registers and aliased reads
    wr(8'h58, 32'h1234); wr(8'h68, 32'hA5);
    rd(8'h58, 32'h1234, "R4"); rd(8'h5C, 32'h0, "R6"); rd(8'h6C, 32'hA5, "R4");
    // R10 level high on source 3
    wr(8'h50, 32'h8); wr(8'h70, 32'h8);
    drive(3, 1);
    pin(1, 1, "R10"); rd(8'h54, 32'h8, "R5"); rd(8'h50, 32'h8, "R4"); pin(3, 1, "R12");
    drive(3, 0);
    pin(1, 0, "R10"); pin(3, 0, "R12");
    // R11 level low on source 4 routed to request 1
    wr(8'h50, 32'h10); wr(8'h40, 32'h10); wr(8'h60, 32'h10); wr(8'h70, 32'h10);
    pin(2, 1, "R11"); pin(1, 0, "R11"); rd(8'h5C, 32'h10, "R6"); rd(8'h54, 32'h0, "R5");
    pin(3, 1, "R12");
    drive(4, 1);
    pin(2, 0, "R10");
    // R9 rising edge on source 0 latches
    wr(8'h40, 32'h1); wr(8'h70, 32'h1);
    drive(0, 1);
    pin(1, 1, "R9");
    drive(0, 0);
    pin(1, 1, "R9"); rd(8'h54, 32'h1, "R5");
    wr(8'h74, 32'h1);
    pin(1, 0, "R9"); rd(8'h70, 32'h18, "R9");
    wr(8'h70, 32'h1);
    pin(1, 0, "R9");
    // R8 falling edge on source 1
    wr(8'h48, 32'h2);
    drive(1, 1);
    wr(8'h70, 32'h2);
    pin(1, 0, "R8");
    drive(1, 0);
    pin(1, 1, "R8"); rd(8'h54, 32'h2, "R5");
    wr(8'h74, 32'h2);
    pin(1, 0, "R9");
    // R13 masked source latches but stays quiet
    wr(8'h40, 32'h4);
    drive(2, 1); drive(2, 0);
    pin(1, 0, "R13"); rd(8'h54, 32'h0, "R13");
    wr(8'h70, 32'h4);
    pin(1, 1, "R13"); rd(8'h54, 32'h4, "R13");
    wr(8'h74, 32'h4);
    // R8 code 6 behaves as off
    wr(8'h50, 32'h20); wr(8'h48, 32'h20); wr(8'h70, 32'h20);
    drive(5, 1);
    pin(1, 0, "R8"); pin(2, 0, "R8");
    drive(5, 0);
    // R8 either edge on source 6
    wr(8'h40, 32'h40); wr(8'h48, 32'h40); wr(8'h70, 32'h40);
    drive(6, 1);
    pin(1, 1, "R8");
    wr(8'h74, 32'h40);
    pin(1, 0, "R9");
    wr(8'h70, 32'h40);
    drive(6, 0);
    pin(1, 1, "R8");
    wr(8'h74, 32'h40);
    pin(3, 0, "R12");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule